// File: doc/BRIEF.md
# Oversampled Type B Frame Receiver

This block recovers reader-to-card frames of the 106 kbit/s Type B proximity protocol from a stream of hard-decision line samples. Each bit period is covered by four samples, and a sample is accepted only on a clock where the sample-valid strobe is high. The receiver synchronises on the long low start-of-frame pulse. It then collects 10-bit characters: a low start bit, eight data bits sent least significant first, and a high stop bit. Each good byte is written out with its position in the frame.

A character that is low in all ten bits closes the frame and produces a one-cycle done pulse with the byte count, but only if the frame holds at least one byte. Any other malformed character, a start-of-frame pulse outside its length window, an over-long idle between characters, or a frame that reaches the byte limit drops the receiver back to hunting for a new frame. An in-frame flag is high from acceptance of the start-of-frame until the frame ends for any reason.

Top module: `typeb_frame_rx`

## Requirements
- R1: Only samples taken with `smp_valid_i` high advance the receiver. Counting valid samples from the one that anchors a phase, a bit is read on the third valid sample of every group of four.
- R2: Starting from idle, the first low sample anchors the start-of-frame phase. The frame is accepted when a high bit is read after at least 10 low bits. `in_frame_o` rises on the clock after the sample that read that high bit. With 9 or fewer low bits no frame starts.
- R3: When the 13th consecutive low bit is read during start-of-frame, the attempt is abandoned and no frame starts.
- R4: After start-of-frame or after a character, up to 25 consecutive high samples are tolerated before a start bit. The 26th high sample ends the frame, and `in_frame_o` falls on the following clock.
- R5: A character begins at the first low sample after the gap. Its ten read bits hold the start bit first and the stop bit last. If start is 0 and stop is 1, the eight middle bits form the byte, least significant bit first. `byte_we_o` pulses for one clock after the sample that read the stop bit, with `byte_o` and `byte_idx_o` giving the byte and its position from 0.
- R6: A character whose ten read bits are all 0 ends the frame. On the clock after its last read, `in_frame_o` falls. In the same cycle `frame_done_o` pulses with `frame_len_o` equal to the number of bytes written, but only if that number is nonzero.
- R7: Any other character, for example a nonzero one with a low stop bit, ends the frame without a byte write or a done pulse.
- R8: The write of byte number `MAX_BYTES` (index `MAX_BYTES-1`) still takes place, and in that same cycle `in_frame_o` falls. That frame then produces no done pulse.
- R9: A synchronous reset, active high on `rst`, returns the receiver to idle with `in_frame_o`, `byte_we_o` and `frame_done_o` low, even in the middle of a frame.
- R10: The byte index restarts at 0 for every newly accepted frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid_i | input | 1 | Line sample strobe |
| smp_i | input | 1 | Hard-decision line sample |
| byte_we_o | output | 1 | One-cycle byte write strobe |
| byte_o | output | 8 | Received byte |
| byte_idx_o | output | IDX_W (8) | Position of the byte in the frame |
| frame_done_o | output | 1 | One-cycle end-of-frame pulse |
| frame_len_o | output | LEN_W (9) | Byte count of the finished frame |
| in_frame_o | output | 1 | High while a frame is being received |

## Verification
Every result is registered, so each one appears on the clock after the valid sample that decides it. The start-of-frame acceptance is due after the sample 4k+2 past the anchor, where k is the number of low bits. A byte write, done pulse or frame end is due after the sample 38 past the start bit of its character, and a gap timeout after the 26th high sample. The bench numbers every valid sample it drives and derives these due indices arithmetically while it builds the stimulus. On each falling edge it compares all outputs against the events due for the sample consumed at the preceding rising edge, so an early, late, missing or extra event fails at once.

// File: rtl/typeb_rx_pkg.sv
package typeb_rx_pkg;

    // Bits per character: start, eight data, stop
    localparam int CHAR_BITS = 10;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SOF_LOW = 2'd1,
        ST_GAP     = 2'd2,
        ST_DATA    = 2'd3
    } rx_state_e;

    typedef enum logic [1:0] {
        CH_DATA = 2'd0,
        CH_EOF  = 2'd1,
        CH_BAD  = 2'd2
    } char_kind_e;

endpackage

// File: rtl/typeb_char_classify.sv
module typeb_char_classify
    import typeb_rx_pkg::*;
(
    input  logic [CHAR_BITS-1:0] chr_i,
    output char_kind_e           kind_o,
    output logic [7:0]           data_o
);

    assign data_o = chr_i[8:1];

    always_comb begin
        if (chr_i == '0) begin
            kind_o = CH_EOF;
        end else if (chr_i[CHAR_BITS-1] && !chr_i[0]) begin
            kind_o = CH_DATA;
        end else begin
            kind_o = CH_BAD;
        end
    end

endmodule

// File: rtl/typeb_rx_ctrl.sv
module typeb_rx_ctrl
    import typeb_rx_pkg::*;
#(
    parameter int SPB           = 4,
    parameter int SOF_MIN_BITS  = 10,
    parameter int SOF_MAX_BITS  = 12,
    parameter int GAP_MAX       = 25,
    parameter int MAX_BYTES     = 256,
    localparam int IDX_W        = $clog2(MAX_BYTES),
    localparam int LEN_W        = $clog2(MAX_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_valid_i,
    input  logic             smp_i,
    output logic             byte_we_o,
    output logic [7:0]       byte_o,
    output logic [IDX_W-1:0] byte_idx_o,
    output logic             frame_done_o,
    output logic [LEN_W-1:0] frame_len_o,
    output logic             in_frame_o
);

    localparam int READ_PHASE = SPB / 2;
    localparam int PW = $clog2(SPB + 1);
    localparam int BW = $clog2(SOF_MAX_BITS + 2);
    localparam int GW = $clog2(GAP_MAX + 2);
    localparam int CW = $clog2(CHAR_BITS + 1);

    typedef struct packed {
        rx_state_e              state;
        logic [PW-1:0]          pos;
        logic [BW-1:0]          low_bits;
        logic [CW-1:0]          chr_bits;
        logic [GW-1:0]          gap;
        logic [CHAR_BITS-1:0]   shreg;
        logic [LEN_W-1:0]       cnt;
        logic                   we;
        logic [7:0]             data;
        logic [IDX_W-1:0]       idx;
        logic                   done;
        logic [LEN_W-1:0]       len;
        logic                   in_frame;
    } ctrl_t;

    ctrl_t q, d;

    logic [PW-1:0]        pos_inc, pos_wrap;
    logic                 read_pt;
    logic [BW-1:0]        low_inc;
    logic [GW-1:0]        gap_inc;
    logic [CW-1:0]        chr_inc;
    logic [LEN_W-1:0]     cnt_inc;
    logic [CHAR_BITS-1:0] shifted;
    char_kind_e           kind;
    logic [7:0]           chr_byte;

    assign pos_inc  = q.pos + 1'b1;
    assign read_pt  = (pos_inc == PW'(READ_PHASE));
    assign pos_wrap = (pos_inc == PW'(SPB)) ? '0 : pos_inc;
    assign low_inc  = q.low_bits + 1'b1;
    assign gap_inc  = q.gap + 1'b1;
    assign chr_inc  = q.chr_bits + 1'b1;
    assign cnt_inc  = q.cnt + 1'b1;
    // New bit enters at the top, so the first bit of a character ends at bit 0
    assign shifted  = {smp_i, q.shreg[CHAR_BITS-1:1]};

    typeb_char_classify i_classify (
        .chr_i  (shifted),
        .kind_o (kind),
        .data_o (chr_byte)
    );

    always_comb begin
        d      = q;
        d.we   = 1'b0;
        d.done = 1'b0;
        if (smp_valid_i) begin
            unique case (q.state)
                ST_IDLE: begin
                    if (!smp_i) begin
                        d.state    = ST_SOF_LOW;
                        d.pos      = '0;
                        d.low_bits = '0;
                        d.cnt      = '0;
                    end
                end
                ST_SOF_LOW: begin
                    d.pos = pos_wrap;
                    if (read_pt) begin
                        if (smp_i) begin
                            if (q.low_bits >= BW'(SOF_MIN_BITS)) begin
                                d.state    = ST_GAP;
                                d.gap      = '0;
                                d.in_frame = 1'b1;
                            end else begin
                                d.state = ST_IDLE;
                            end
                        end else begin
                            d.low_bits = low_inc;
                            if (low_inc > BW'(SOF_MAX_BITS)) begin
                                d.state = ST_IDLE;
                            end
                        end
                    end
                end
                ST_GAP: begin
                    if (smp_i) begin
                        d.gap = gap_inc;
                        if (gap_inc > GW'(GAP_MAX)) begin
                            d.state    = ST_IDLE;
                            d.in_frame = 1'b0;
                        end
                    end else begin
                        d.state    = ST_DATA;
                        d.pos      = '0;
                        d.chr_bits = '0;
                        d.shreg    = '0;
                    end
                end
                ST_DATA: begin
                    d.pos = pos_wrap;
                    if (read_pt) begin
                        d.shreg    = shifted;
                        d.chr_bits = chr_inc;
                        if (chr_inc == CW'(CHAR_BITS)) begin
                            case (kind)
                                CH_DATA: begin
                                    d.we   = 1'b1;
                                    d.data = chr_byte;
                                    d.idx  = q.cnt[IDX_W-1:0];
                                    d.cnt  = cnt_inc;
                                    if (cnt_inc == LEN_W'(MAX_BYTES)) begin
                                        d.state    = ST_IDLE;
                                        d.in_frame = 1'b0;
                                    end else begin
                                        d.state = ST_GAP;
                                        d.gap   = '0;
                                    end
                                end
                                CH_EOF: begin
                                    d.state    = ST_IDLE;
                                    d.in_frame = 1'b0;
                                    if (q.cnt != '0) begin
                                        d.done = 1'b1;
                                        d.len  = q.cnt;
                                    end
                                end
                                default: begin
                                    d.state    = ST_IDLE;
                                    d.in_frame = 1'b0;
                                end
                            endcase
                        end
                    end
                end
                default: d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign byte_we_o    = q.we;
    assign byte_o       = q.data;
    assign byte_idx_o   = q.idx;
    assign frame_done_o = q.done;
    assign frame_len_o  = q.len;
    assign in_frame_o   = q.in_frame;

    // R2
    sof_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(q.in_frame) |-> $past(q.state) == ST_SOF_LOW);

    // R4
    gap_bound_chk: assert property (@(posedge clk) disable iff (rst)
        q.state == ST_GAP |-> q.gap <= GW'(GAP_MAX));

    // R5
    we_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        q.we |=> !q.we);

    // R5
    we_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        q.we |-> $past(q.in_frame));

    // R6
    done_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        q.done |-> (q.len != '0) && !q.in_frame && $past(q.in_frame));

    // R8
    limit_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (q.we && q.idx == IDX_W'(MAX_BYTES - 1)) |-> !q.in_frame);

endmodule

// File: rtl/typeb_frame_rx.sv
module typeb_frame_rx #(
    parameter int SPB           = 4,
    parameter int SOF_MIN_BITS  = 10,
    parameter int SOF_MAX_BITS  = 12,
    parameter int GAP_MAX       = 25,
    parameter int MAX_BYTES     = 256,
    localparam int IDX_W        = $clog2(MAX_BYTES),
    localparam int LEN_W        = $clog2(MAX_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_valid_i,
    input  logic             smp_i,
    output logic             byte_we_o,
    output logic [7:0]       byte_o,
    output logic [IDX_W-1:0] byte_idx_o,
    output logic             frame_done_o,
    output logic [LEN_W-1:0] frame_len_o,
    output logic             in_frame_o
);

    typeb_rx_ctrl #(
        .SPB          (SPB),
        .SOF_MIN_BITS (SOF_MIN_BITS),
        .SOF_MAX_BITS (SOF_MAX_BITS),
        .GAP_MAX      (GAP_MAX),
        .MAX_BYTES    (MAX_BYTES)
    ) i_ctrl (
        .clk          (clk),
        .rst          (rst),
        .smp_valid_i  (smp_valid_i),
        .smp_i        (smp_i),
        .byte_we_o    (byte_we_o),
        .byte_o       (byte_o),
        .byte_idx_o   (byte_idx_o),
        .frame_done_o (frame_done_o),
        .frame_len_o  (frame_len_o),
        .in_frame_o   (in_frame_o)
    );

endmodule

// File: tb/test_typeb_frame_rx.sv
module test_typeb_frame_rx;

    localparam int MAXB  = 8;
    localparam int IDX_W = $clog2(MAXB);
    localparam int LEN_W = $clog2(MAXB + 1);

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic             rst = 1'b1;
    logic             smp_valid = 1'b0;
    logic             smp = 1'b1;
    logic             byte_we;
    logic [7:0]       byte_d;
    logic [IDX_W-1:0] byte_idx;
    logic             frame_done;
    logic [LEN_W-1:0] frame_len;
    logic             in_frame;

    typeb_frame_rx #(.MAX_BYTES(MAXB)) i_typeb_frame_rx (
        .clk          (clk),
        .rst          (rst),
        .smp_valid_i  (smp_valid),
        .smp_i        (smp),
        .byte_we_o    (byte_we),
        .byte_o       (byte_d),
        .byte_idx_o   (byte_idx),
        .frame_done_o (frame_done),
        .frame_len_o  (frame_len),
        .in_frame_o   (in_frame)
    );

    // kind: 0 byte write, 1 done, 2 in-frame rise, 3 in-frame fall
    typedef struct {
        int    at;
        int    kind;
        int    data;
        int    idx;
        string req;
    } ev_t;

    typedef logic [7:0] byte_q_t[$];

    ev_t   exp_q[$];
    bit    stim_q[$];
    int    nxt = 0;
    int    drv_idx = 0;
    int    checks = 0;
    int    fails = 0;
    bit    sparse = 1'b0;
    bit    tog = 1'b0;
    bit    prev_valid = 1'b0;
    int    prev_idx = 0;
    logic  prev_if = 1'b0;
    string cur_tag = "";

    task automatic push(input bit v, input int n);
        repeat (n) begin
            stim_q.push_back(v);
            nxt++;
        end
    endtask

    task automatic ev(input int at, input int kind, input int data, input int idx, input string req);
        ev_t e;
        e.at   = at;
        e.kind = kind;
        e.data = data;
        e.idx  = idx;
        e.req  = (cur_tag != "") ? cur_tag : req;
        exp_q.push_back(e);
    endtask

    // start bit, data LSB first, stop bit; four samples each
    task automatic send_char(input logic [7:0] dat, input bit stop, output int c);
        c = nxt + 38;
        push(1'b0, 4);
        for (int i = 0; i < 8; i++) push(dat[i], 4);
        push(stop, 4);
    endtask

    task automatic send_frame(input byte_q_t dat, input int k, input int gs, input int gc);
        int s0, a, c, n;
        s0 = nxt;
        push(1'b0, 4 * k);
        a = s0 + 2 + 4 * k;
        push(1'b1, 3 + gs);
        ev(a, 2, 0, 0, "R2");
        n = 0;
        foreach (dat[j]) begin
            if (n > 0) push(1'b1, gc - 1);
            send_char(dat[j], 1'b1, c);
            ev(c, 0, int'(dat[j]), n, "R5");
            n++;
            if (n == MAXB) begin
                ev(c, 3, 0, 0, "R8");
                push(1'b1, 60);
                return;
            end
        end
        if (n > 0) push(1'b1, gc - 1);
        send_char(8'h00, 1'b0, c);
        if (n > 0) ev(c, 1, n, 0, "R6");
        ev(c, 3, 0, 0, "R6");
        push(1'b1, 60);
    endtask

    task automatic fail_line(input string req, input string what);
        fails++;
        $display("FAIL %s: %s", req, what);
    endtask

    task automatic monitor();
        int    cons;
        bit    e_we, e_done, e_rise, e_fall;
        int    e_data, e_idx, e_len;
        string t_we, t_done, t_if;
        logic  exp_if;
        e_we = 0; e_done = 0; e_rise = 0; e_fall = 0;
        e_data = 0; e_idx = 0; e_len = 0;
        t_we   = (cur_tag != "") ? cur_tag : "R5";
        t_done = (cur_tag != "") ? cur_tag : "R6";
        t_if   = (cur_tag != "") ? cur_tag : "R2";
        cons = prev_valid ? prev_idx : -1;
        while (cons >= 0 && exp_q.size() > 0 && exp_q[0].at <= cons) begin
            ev_t e;
            e = exp_q.pop_front();
            if (e.at < cons) begin
                checks++;
                fail_line(e.req, $sformatf("event kind %0d missed, actual none, expected at sample %0d", e.kind, e.at));
            end else begin
                case (e.kind)
                    0: begin e_we = 1; e_data = e.data; e_idx = e.idx; t_we = e.req; end
                    1: begin e_done = 1; e_len = e.data; t_done = e.req; end
                    2: begin e_rise = 1; t_if = e.req; end
                    default: begin e_fall = 1; t_if = e.req; end
                endcase
            end
        end
        checks++;
        if (byte_we !== e_we || (e_we && (byte_d !== e_data[7:0] || int'(byte_idx) != e_idx)))
            fail_line(t_we, $sformatf("sample %0d actual we=%0b byte=%02h idx=%0d, expected we=%0b byte=%02h idx=%0d",
                      cons, byte_we, byte_d, byte_idx, e_we, e_data, e_idx));
        checks++;
        if (frame_done !== e_done || (e_done && int'(frame_len) != e_len))
            fail_line(t_done, $sformatf("sample %0d actual done=%0b len=%0d, expected done=%0b len=%0d",
                      cons, frame_done, frame_len, e_done, e_len));
        exp_if = e_rise ? 1'b1 : (e_fall ? 1'b0 : prev_if);
        checks++;
        if (in_frame !== exp_if)
            fail_line(t_if, $sformatf("sample %0d actual in_frame=%0b, expected %0b", cons, in_frame, exp_if));
        prev_if = exp_if;
    endtask

    task automatic step();
        @(negedge clk);
        monitor();
        tog = sparse ? ~tog : 1'b1;
        if (stim_q.size() > 0 && tog) begin
            smp_valid  = 1'b1;
            smp        = stim_q.pop_front();
            prev_valid = 1'b1;
            prev_idx   = drv_idx;
            drv_idx++;
        end else begin
            smp_valid  = 1'b0;
            smp        = 1'b1;
            prev_valid = 1'b0;
        end
    endtask

    task automatic run();
        while (stim_q.size() > 0) step();
        repeat (4) step();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fail_line("R9", "watchdog expired, actual running, expected finished");
        summary();
        $finish;
    end

    initial begin
        byte_q_t empty_q;
        int s0, a, c;

        // R9: reset state
        repeat (3) @(negedge clk);
        checks++;
        if (in_frame !== 1'b0 || byte_we !== 1'b0 || frame_done !== 1'b0)
            fail_line("R9", $sformatf("actual if=%0b we=%0b done=%0b, expected 0 0 0", in_frame, byte_we, frame_done));
        rst = 1'b0;
        prev_if = 1'b0;

        // R5 R6: basic frame, minimum SOF, back-to-back characters
        send_frame('{8'h05, 8'h00, 8'hA5}, 10, 3, 1);
        run();

        // R4: longest SOF and maximum tolerated gaps
        send_frame('{8'hFF, 8'h3C, 8'h81, 8'h7E}, 12, 25, 25);
        run();

        // R1: samples spread over alternate clocks
        cur_tag = "R1";
        sparse = 1'b1;
        send_frame('{8'hC3, 8'h18}, 11, 0, 2);
        run();
        sparse = 1'b0;
        cur_tag = "";

        // R2: SOF of 9 low bits is rejected
        cur_tag = "R2";
        push(1'b0, 36);
        push(1'b1, 60);
        run();
        cur_tag = "";

        // R3: 13 low bits abandon the attempt
        cur_tag = "R3";
        push(1'b0, 52);
        push(1'b1, 60);
        run();
        cur_tag = "";

        // R4: 26 high samples after SOF time out
        s0 = nxt;
        push(1'b0, 40);
        push(1'b1, 80);
        a = s0 + 42;
        ev(a, 2, 0, 0, "R4");
        ev(a + 26, 3, 0, 0, "R4");
        run();

        // R7: nonzero character with low stop bit
        s0 = nxt;
        push(1'b0, 40);
        push(1'b1, 5);
        ev(s0 + 42, 2, 0, 0, "R7");
        send_char(8'h5A, 1'b0, c);
        ev(c, 3, 0, 0, "R7");
        push(1'b1, 60);
        run();

        // R6: end-of-frame with no bytes gives no done pulse
        send_frame(empty_q, 10, 2, 1);
        run();

        // R8: byte limit aborts the frame
        send_frame('{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'h09}, 10, 1, 1);
        run();

        // R10: consecutive frames restart the index
        cur_tag = "R10";
        send_frame('{8'h11}, 10, 2, 1);
        send_frame('{8'h22, 8'h33}, 11, 4, 3);
        run();
        cur_tag = "";

        // R9: reset in the middle of a frame
        s0 = nxt;
        push(1'b0, 40);
        push(1'b1, 8);
        ev(s0 + 42, 2, 0, 0, "R9");
        run();
        @(negedge clk);
        rst = 1'b1;
        smp_valid = 1'b0;
        prev_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        checks++;
        if (in_frame !== 1'b0 || byte_we !== 1'b0 || frame_done !== 1'b0)
            fail_line("R9", $sformatf("actual if=%0b we=%0b done=%0b, expected 0 0 0", in_frame, byte_we, frame_done));
        prev_if = 1'b0;
        repeat (4) step();

        checks++;
        if (exp_q.size() != 0)
            fail_line("R5", $sformatf("actual %0d events outstanding, expected 0", exp_q.size()));

        summary();
        $finish;
    end

endmodule